// File: doc/BRIEF.md
# Legacy Keyboard Controller Emulator

This block stands in for the classic keyboard and mouse controller on behalf of a host controller. Two agents see it. Legacy code reaches it through byte-wide I/O reads and writes to the data port (60h) and the command port (64h). Emulation software reaches it through a 32-bit register window. The block stores the byte last sent by legacy code, the byte waiting to be returned, and the controller status flags. Hardware updates those flags as the legacy ports are used.

The block routes the output-full flag to either the keyboard interrupt line (IRQ1) or the mouse interrupt line (IRQ12). It also raises an emulation interrupt whenever software needs to step in: when legacy code has written a byte, or when software asked to be told that the output byte has been consumed. A reduced gate-A20 handshake is included. A command byte of D1h arms it, and the next data-port write then drives an A20 output bit. That data write does not raise input-full.

All register and port reads are combinational. Every state change lands on the clock edge that follows the access.

Top module: `kbc_emu_top`

## Requirements
- R1: After reset, every register reads 0, and `irq1`, `irq12`, `emu_irq` and `a20_out` are all low.
- R2: Legacy accesses to 60h/64h are decoded only while control bit 0 (emulation enable) is 1. Otherwise `io_hit` stays 0, `io_rdata` reads 0 and no state changes.
- R3: A decoded write to either port stores its byte in bits 7:0 of the input register (offset 104h), readable the next cycle.
- R4: A decoded write clears status bit 3 (command/data) for port 60h and sets it for port 64h.
- R5: A decoded write sets status bit 1 (input-full), except for the A20 data write of R10.
- R6: A decoded read of 60h returns bits 7:0 of the output register (offset 108h) and clears status bit 0 (output-full) on the next edge. A decoded read of 64h returns the status byte and changes nothing.
- R7: With control bit 3 (interrupt enable) and status bit 0 both 1, the block drives `irq12` if status bit 5 (aux) is 1 and `irq1` otherwise. Both lines are low in every other case.
- R8: `emu_irq` is high while (enable AND status bit 1) OR (control bit 2 AND NOT status bit 0). Control bit 1 reads back this same value and is read-only.
- R9: Bits 31:8 of the input, output and status registers read 0 and ignore writes. In the control register only bits 0, 2, 3 and 8 are writable, and the other bits read 0.
- R10: A decoded write of D1h to 64h arms the A20 state. The next decoded 60h write sets control bit 8 / `a20_out` to bit 1 of its byte, does not set input-full, and disarms. Any other 64h write disarms.
- R11: If a legacy access and a software write touch the same flag or byte in one cycle, the legacy update wins.
- R12: Register offsets are 100h (control), 104h (input), 108h (output) and 10Ch (status). `reg_rdata` is 0 for any other offset, and also whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Legacy I/O access this cycle |
| io_write | input | 1 | 1 = legacy write, 0 = legacy read |
| io_addr | input | 16 | Legacy I/O port address |
| io_wdata | input | 8 | Legacy write byte |
| io_rdata | output | 8 | Legacy read byte (combinational) |
| io_hit | output | 1 | Access decoded as 60h/64h while enabled |
| reg_valid | input | 1 | Software register access this cycle |
| reg_write | input | 1 | 1 = register write, 0 = register read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq1 | output | 1 | Keyboard interrupt line |
| irq12 | output | 1 | Mouse interrupt line |
| emu_irq | output | 1 | Emulation interrupt to software |
| a20_out | output | 1 | Gate-A20 output bit |

## Verification
Read data on either side (`io_rdata`, `reg_rdata`) and `io_hit` depend on the state before the clock edge, so they are due in the same cycle as the access. Every flag, byte and interrupt change caused by an access is due one edge later, because each passes through exactly one register, and `irq1`, `irq12` and `emu_irq` follow combinationally from it. The bench drives each access just after a falling edge and compares every output against its model 1 ns later. It applies the access to its model at the rising edge, so the next comparison sees the one-cycle-late effects exactly where they are due.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  // control register bit positions
  localparam int unsigned CT_ENABLE  = 0;
  localparam int unsigned CT_EMU     = 1;
  localparam int unsigned CT_CHPEND  = 2;
  localparam int unsigned CT_IRQEN   = 3;
  localparam int unsigned CT_A20     = 8;

  // status byte bit positions
  localparam int unsigned ST_OBF     = 0;
  localparam int unsigned ST_IBF     = 1;
  localparam int unsigned ST_CMD     = 3;
  localparam int unsigned ST_AUX     = 5;

  // decoded legacy events, at most one per cycle
  typedef struct packed {
    logic wr_data;
    logic wr_cmd;
    logic rd_data;
    logic rd_stat;
  } io_ev_t;

  function automatic logic emu_condition(input logic en, input logic ibf,
                                         input logic chpend, input logic obf);
    return (en & ibf) | (chpend & ~obf);
  endfunction

  // returns {irq12, irq1}
  function automatic logic [1:0] irq_route(input logic irqen, input logic obf,
                                           input logic aux);
    logic fire;
    fire = irqen & obf;
    return {fire & aux, fire & ~aux};
  endfunction

endpackage

// File: rtl/kbc_io_decode.sv
module kbc_io_decode
  import kbc_pkg::*;
#(
  parameter int unsigned IO_AW     = 16,
  parameter logic [IO_AW-1:0] DATA_PORT = 'h60,
  parameter logic [IO_AW-1:0] CMD_PORT  = 'h64
) (
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             emu_en,
  output io_ev_t           ev,
  output logic             hit
);

  logic at_data, at_cmd, live;

  assign at_data = (io_addr == DATA_PORT);
  assign at_cmd  = (io_addr == CMD_PORT);
  assign live    = io_valid & emu_en;

  always_comb begin
    ev.wr_data = live &  io_write & at_data;
    ev.wr_cmd  = live &  io_write & at_cmd;
    ev.rd_data = live & ~io_write & at_data;
    ev.rd_stat = live & ~io_write & at_cmd;
  end

  assign hit = live & (at_data | at_cmd);

  always_comb begin
    assert_one_event_R2: assert ($onehot0(ev));
  end

endmodule

// File: rtl/kbc_a20_gate.sv
module kbc_a20_gate
  import kbc_pkg::*;
#(
  parameter logic [7:0] ARM_CODE = 8'hD1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  io_ev_t     ev,
  input  logic [7:0] io_wdata,
  output logic       a20_wr,
  output logic       armed
);

  logic arm_hit;

  assign arm_hit = ev.wr_cmd & (io_wdata == ARM_CODE);
  assign a20_wr  = armed & ev.wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n)          armed <= 1'b0;
    else if (ev.wr_cmd)  armed <= arm_hit;
    else if (ev.wr_data) armed <= 1'b0;
  end

  assert_arm_on_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm_hit |=> armed);
  assert_disarm_after_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev.wr_data |=> !armed);

endmodule

// File: rtl/kbc_regfile.sv
module kbc_regfile
  import kbc_pkg::*;
#(
  parameter int unsigned RA_W     = 12,
  parameter logic [RA_W-1:0] OFF_CTRL = 'h100,
  parameter logic [RA_W-1:0] OFF_IN   = 'h104,
  parameter logic [RA_W-1:0] OFF_OUT  = 'h108,
  parameter logic [RA_W-1:0] OFF_STAT = 'h10C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_valid,
  input  logic            reg_write,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  io_ev_t          ev,
  input  logic [7:0]      io_wdata,
  input  logic            a20_wr,
  input  logic            emu_irq,
  output logic            emu_en,
  output logic            chpend,
  output logic            irq_en,
  output logic            a20_q,
  output logic [7:0]      st_q,
  output logic [7:0]      out_q
);

  logic [7:0] in_q;
  logic [7:0] st_next;
  logic       sw_wr_ctrl, sw_wr_in, sw_wr_out, sw_wr_st, sw_rd;
  logic       hw_wr;

  assign sw_wr_ctrl = reg_valid & reg_write & (reg_addr == OFF_CTRL);
  assign sw_wr_in   = reg_valid & reg_write & (reg_addr == OFF_IN);
  assign sw_wr_out  = reg_valid & reg_write & (reg_addr == OFF_OUT);
  assign sw_wr_st   = reg_valid & reg_write & (reg_addr == OFF_STAT);
  assign sw_rd      = reg_valid & ~reg_write;
  assign hw_wr      = ev.wr_data | ev.wr_cmd;

  // software first, hardware last so legacy updates win
  always_comb begin
    st_next = st_q;
    if (sw_wr_st)         st_next = reg_wdata[7:0];
    if (ev.wr_data)       st_next[ST_CMD] = 1'b0;
    if (ev.wr_cmd)        st_next[ST_CMD] = 1'b1;
    if (hw_wr && !a20_wr) st_next[ST_IBF] = 1'b1;
    if (ev.rd_data)       st_next[ST_OBF] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emu_en <= 1'b0;
      chpend <= 1'b0;
      irq_en <= 1'b0;
      a20_q  <= 1'b0;
      in_q   <= '0;
      out_q  <= '0;
      st_q   <= '0;
    end else begin
      if (sw_wr_ctrl) begin
        emu_en <= reg_wdata[CT_ENABLE];
        chpend <= reg_wdata[CT_CHPEND];
        irq_en <= reg_wdata[CT_IRQEN];
        a20_q  <= reg_wdata[CT_A20];
      end
      if (a20_wr)    a20_q <= io_wdata[1];
      if (sw_wr_in)  in_q  <= reg_wdata[7:0];
      if (hw_wr)     in_q  <= io_wdata;
      if (sw_wr_out) out_q <= reg_wdata[7:0];
      st_q <= st_next;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sw_rd) begin
      unique case (reg_addr)
        OFF_CTRL: begin
          reg_rdata[CT_ENABLE] = emu_en;
          reg_rdata[CT_EMU]    = emu_irq;
          reg_rdata[CT_CHPEND] = chpend;
          reg_rdata[CT_IRQEN]  = irq_en;
          reg_rdata[CT_A20]    = a20_q;
        end
        OFF_IN:   reg_rdata[7:0] = in_q;
        OFF_OUT:  reg_rdata[7:0] = out_q;
        OFF_STAT: reg_rdata[7:0] = st_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  assert_latch_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_wr |=> in_q == $past(io_wdata));
  assert_cmd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev.wr_data |=> !st_q[ST_CMD]);
  assert_cmd_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev.wr_cmd |=> st_q[ST_CMD]);
  assert_ibf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wr && !a20_wr) |=> st_q[ST_IBF]);
  assert_a20_keeps_ibf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a20_wr && !st_q[ST_IBF] && !sw_wr_st) |=> !st_q[ST_IBF]);
  assert_read_clears_obf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev.rd_data |=> !st_q[ST_OBF]);
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!emu_en && !sw_wr_st) |=> $stable(st_q));

endmodule

// File: rtl/kbc_emu_top.sv
module kbc_emu_top
  import kbc_pkg::*;
#(
  parameter int unsigned IO_AW = 16,
  parameter int unsigned RA_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic             io_hit,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq1,
  output logic             irq12,
  output logic             emu_irq,
  output logic             a20_out
);

  io_ev_t     ev;
  logic       emu_en, chpend, irq_en, a20_q;
  logic       a20_wr, a20_armed;
  logic [7:0] st_q, out_q;
  logic [1:0] irq_pair;

  kbc_io_decode #(.IO_AW(IO_AW)) u_dec (
    .io_valid (io_valid),
    .io_write (io_write),
    .io_addr  (io_addr),
    .emu_en   (emu_en),
    .ev       (ev),
    .hit      (io_hit)
  );

  kbc_a20_gate u_a20 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .io_wdata (io_wdata),
    .a20_wr   (a20_wr),
    .armed    (a20_armed)
  );

  kbc_regfile #(.RA_W(RA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ev        (ev),
    .io_wdata  (io_wdata),
    .a20_wr    (a20_wr),
    .emu_irq   (emu_irq),
    .emu_en    (emu_en),
    .chpend    (chpend),
    .irq_en    (irq_en),
    .a20_q     (a20_q),
    .st_q      (st_q),
    .out_q     (out_q)
  );

  assign irq_pair = irq_route(irq_en, st_q[ST_OBF], st_q[ST_AUX]);
  assign irq12    = irq_pair[1];
  assign irq1     = irq_pair[0];
  assign emu_irq  = emu_condition(emu_en, st_q[ST_IBF], chpend, st_q[ST_OBF]);
  assign a20_out  = a20_q;

  always_comb begin
    io_rdata = '0;
    if (ev.rd_data) io_rdata = out_q;
    if (ev.rd_stat) io_rdata = st_q;
  end

  assert_irq_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq1 && irq12));
  assert_irq_needs_obf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq1 || irq12) |-> (st_q[ST_OBF] && irq_en));
  assert_stat_read_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.rd_stat && !(reg_valid && reg_write)) |=> $stable(st_q));

endmodule

// File: tb/kbc_emu_top_test.sv
`timescale 1ns/1ps
module kbc_emu_top_test;

  localparam time CYC = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iv = 1'b0, iw = 1'b0;
  logic [15:0] ia = '0;
  logic [7:0]  id = '0;
  logic        rv = 1'b0, rw = 1'b0;
  logic [11:0] ra = '0;
  logic [31:0] rd = '0;
  logic [7:0]  io_rdata;
  logic        io_hit;
  logic [31:0] reg_rdata;
  logic        irq1, irq12, emu_irq, a20_out;

  int vectors = 0;
  int misses  = 0;

  // behavioural model state
  bit       m_en, m_cp, m_irqen, m_a20, m_armed;
  bit [7:0] m_st, m_in, m_out;

  always #(CYC/2) clk = ~clk;

  kbc_emu_top uut (
    .clk(clk), .rst_n(rst_n),
    .io_valid(iv), .io_write(iw), .io_addr(ia), .io_wdata(id),
    .io_rdata(io_rdata), .io_hit(io_hit),
    .reg_valid(rv), .reg_write(rw), .reg_addr(ra), .reg_wdata(rd),
    .reg_rdata(reg_rdata),
    .irq1(irq1), .irq12(irq12), .emu_irq(emu_irq), .a20_out(a20_out)
  );

  task automatic cmp(input string tag, input string sig, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, sig, act, exp, $time);
    end
  endtask

  function automatic bit legacy_hit();
    return iv && m_en && (ia == 16'h60 || ia == 16'h64);
  endfunction

  task automatic check_all(input string tag);
    bit [31:0] er;
    bit [7:0]  eio;
    bit        emu;
    emu = (m_en && m_st[1]) || (m_cp && !m_st[0]);
    eio = 8'h00;
    if (legacy_hit() && !iw) eio = (ia == 16'h60) ? m_out : m_st;
    er = 32'h0;
    if (rv && !rw) begin
      if (ra == 12'h100) er = {23'h0, m_a20, 4'h0, m_irqen, m_cp, emu, m_en};
      else if (ra == 12'h104) er = {24'h0, m_in};
      else if (ra == 12'h108) er = {24'h0, m_out};
      else if (ra == 12'h10C) er = {24'h0, m_st};
    end
    cmp(tag, "io_hit",    {31'h0, io_hit},  {31'h0, legacy_hit()});
    cmp(tag, "io_rdata",  {24'h0, io_rdata}, {24'h0, eio});
    cmp(tag, "reg_rdata", reg_rdata, er);
    cmp(tag, "irq1",  {31'h0, irq1},  {31'h0, m_irqen && m_st[0] && !m_st[5]});
    cmp(tag, "irq12", {31'h0, irq12}, {31'h0, m_irqen && m_st[0] &&  m_st[5]});
    cmp(tag, "emu_irq", {31'h0, emu_irq}, {31'h0, emu});
    cmp(tag, "a20_out", {31'h0, a20_out}, {31'h0, m_a20});
  endtask

  task automatic model_edge();
    bit hit, w60, w64, r60, a20d;
    hit  = legacy_hit();
    w60  = hit && iw && ia == 16'h60;
    w64  = hit && iw && ia == 16'h64;
    r60  = hit && !iw && ia == 16'h60;
    a20d = w60 && m_armed;
    if (rv && rw) begin
      case (ra)
        12'h100: begin m_en = rd[0]; m_cp = rd[2]; m_irqen = rd[3]; m_a20 = rd[8]; end
        12'h104: m_in  = rd[7:0];
        12'h108: m_out = rd[7:0];
        12'h10C: m_st  = rd[7:0];
        default: ;
      endcase
    end
    if (w60 || w64) m_in = id;
    if (w60) m_st[3] = 1'b0;
    if (w64) m_st[3] = 1'b1;
    if ((w60 || w64) && !a20d) m_st[1] = 1'b1;
    if (r60) m_st[0] = 1'b0;
    if (a20d) m_a20 = id[1];
    if (w64) m_armed = (id == 8'hD1);
    else if (w60) m_armed = 1'b0;
  endtask

  // one cycle: drive at falling edge, compare, apply at rising edge
  task automatic step(input string tag, input bit r_v, input bit r_w,
                      input logic [11:0] r_a, input logic [31:0] r_d,
                      input bit i_v, input bit i_w, input logic [15:0] i_a,
                      input logic [7:0] i_d);
    rv = r_v; rw = r_w; ra = r_a; rd = r_d;
    iv = i_v; iw = i_w; ia = i_a; id = i_d;
    #1ns;
    check_all(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic swr(input string tag, input logic [11:0] a, input logic [31:0] d);
    step(tag, 1, 1, a, d, 0, 0, 16'h0, 8'h0);
  endtask
  task automatic srd(input string tag, input logic [11:0] a);
    step(tag, 1, 0, a, 32'h0, 0, 0, 16'h0, 8'h0);
  endtask
  task automatic iow(input string tag, input logic [15:0] a, input logic [7:0] d);
    step(tag, 0, 0, 12'h0, 32'h0, 1, 1, a, d);
  endtask
  task automatic ior(input string tag, input logic [15:0] a);
    step(tag, 0, 0, 12'h0, 32'h0, 1, 0, a, 8'h0);
  endtask

  initial begin
    #(CYC * 150000);
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on every register
    srd("R1 ctrl", 12'h100);
    srd("R1 in",   12'h104);
    srd("R1 out",  12'h108);
    srd("R1 stat", 12'h10C);
    // R2: disabled, legacy traffic ignored
    iow("R2 wr60 off", 16'h60, 8'hA5);
    iow("R2 wr64 off", 16'h64, 8'hD1);
    ior("R2 rd64 off", 16'h64);
    srd("R2 stat", 12'h10C);
    srd("R2 in",   12'h104);
    // enable emulation
    swr("R8 enable", 12'h100, 32'h1);
    // R3 R4 R5
    iow("R3 wr60", 16'h60, 8'h5A);
    srd("R3 in",   12'h104);
    srd("R4 stat", 12'h10C);
    srd("R8 ctrl emu", 12'h100);
    iow("R4 wr64", 16'h64, 8'hAA);
    srd("R4 stat", 12'h10C);
    iow("R2 other port", 16'h61, 8'h77);
    srd("R3 in kept", 12'h104);
    // R6 R7: software loads output, enables interrupts
    swr("R6 out", 12'h108, 32'h0000_0033);
    swr("R7 stat", 12'h10C, 32'h0000_0001);
    swr("R7 irqen", 12'h100, 32'h9);
    ior("R6 rd64", 16'h64);
    ior("R6 rd60", 16'h60);
    srd("R6 stat", 12'h10C);
    swr("R7 aux", 12'h10C, 32'h0000_0021);
    srd("R7 irq12", 12'h10C);
    ior("R6 rd60 aux", 16'h60);
    // R8: character pending with output empty
    swr("R8 chpend", 12'h100, 32'hD);
    srd("R8 ctrl", 12'h100);
    swr("R8 ro bit", 12'h100, 32'h2);
    srd("R8 ctrl ro", 12'h100);
    swr("R10 reen", 12'h100, 32'h1);
    // R10: A20 sequence
    swr("R10 clr", 12'h10C, 32'h0);
    iow("R10 arm", 16'h64, 8'hD1);
    swr("R10 clr2", 12'h10C, 32'h0);
    iow("R10 data", 16'h60, 8'h02);
    srd("R10 stat", 12'h10C);
    srd("R10 ctrl", 12'h100);
    iow("R10 arm2", 16'h64, 8'hD1);
    iow("R10 disarm", 16'h64, 8'h10);
    swr("R10 clr3", 12'h10C, 32'h0);
    iow("R10 plain", 16'h60, 8'h00);
    srd("R10 stat2", 12'h10C);
    // R11: collisions
    swr("R11 obf", 12'h10C, 32'h1);
    step("R11 rd vs sw", 1, 1, 12'h10C, 32'h0000_0001, 1, 0, 16'h60, 8'h0);
    srd("R11 stat", 12'h10C);
    step("R11 wr vs sw", 1, 1, 12'h10C, 32'h0000_0000, 1, 1, 16'h64, 8'h44);
    srd("R11 stat2", 12'h10C);
    step("R11 in vs sw", 1, 1, 12'h104, 32'h0000_00EE, 1, 1, 16'h60, 8'h11);
    srd("R11 in", 12'h104);
    // R9 reserved bits, R12 offsets
    swr("R9 ctrl", 12'h100, 32'hFFFF_FFFF);
    srd("R9 ctrl", 12'h100);
    swr("R9 in",   12'h104, 32'hFFFF_FF3C);
    srd("R9 in",   12'h104);
    swr("R9 out",  12'h108, 32'hFFFF_FFC3);
    srd("R9 out",  12'h108);
    swr("R9 stat", 12'h10C, 32'hFFFF_FF00);
    srd("R9 stat", 12'h10C);
    swr("R12 hole", 12'h110, 32'hFFFF_FFFF);
    srd("R12 hole", 12'h110);
    srd("R12 low",  12'h000);
    step("R12 no rd", 0, 0, 12'h100, 32'h0, 0, 0, 16'h0, 8'h0);
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [11:0] a;
      logic [15:0] p;
      logic [7:0]  d;
      a = 12'h100 + 12'(($urandom % 5) * 4);
      p = ($urandom % 4 == 0) ? 16'h61 : (($urandom % 2) ? 16'h60 : 16'h64);
      d = ($urandom % 6 == 0) ? 8'hD1 : 8'($urandom);
      step("R11 mix", ($urandom % 3) != 0, ($urandom % 2) == 1, a, $urandom,
           ($urandom % 2) == 1, ($urandom % 2) == 1, p, d);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule